// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block holds the per-vector state of a message-signalled interrupt function. Each vector has a 64-bit target address, a 32-bit payload word and its own mask bit. A function-wide mask sits above all the vectors; it is derived from an enable bit and a mask-everything bit. Software reaches the entries through a byte-addressed 32-bit register port. It reads the pending bits through a second port that is read-only. It also writes the two function bits through a small control port, which reports the table size as well.

Each cycle the interrupt source may raise one request that names a vector. If the vector is in use and not masked, the block queues a memory-write message: the entry's data word sent to the entry's address. If the vector is masked, the block sets the vector's pending bit and sends nothing. Any change from masked to unmasked replays the vector if it is pending. The change can come from a per-vector mask write, a function mask release or the enable bit being set. Replayed messages share one valid/ready output with normal messages. A rotating sweep over all entries issues them in index order.

Top module: `mvec_ctrl`

## Requirements
- R1: After reset, the enable and mask-everything bits read 0, and every entry's address and data words read 0. Every entry's control word reads 1 (masked), every pending bit is 0, and the size field reads NUM_VEC-1.
- R2: The table is byte-addressed with 16 bytes per vector, and bits [3:2] of the address select the word: 0 = address low, 1 = address high, 2 = data, 3 = control. Only bit 0 of the control word (the mask) is stored. Its other bits read 0.
- R3: A vector's effective mask is its own mask bit OR the function mask. The function mask is set whenever the enable bit is 0 or the mask-everything bit is 1.
- R4: A request to an in-use vector whose effective mask is set sets that vector's pending bit and sends no message.
- R5: A request to an in-use, unmasked vector sends one message carrying that entry's 64-bit address and 32-bit data, and leaves its pending bit at 0.
- R6: A request is ignored when the vector index is NUM_VEC or above, or when the vector's in-use bit is 0.
- R7: When a vector's effective mask goes from 1 to 0 and its pending bit is set, the bit clears and the vector's message is sent. A mask write that leaves the effective mask unchanged, or an unmask with no pending bit, sends nothing.
- R8: Releasing the function mask replays every pending vector whose own mask bit is 0. Vectors whose own mask is still set keep their pending bits.
- R9: The pending bit of vector v is bit v mod 32 of 32-bit word v div 32 of the pending array (byte v div 8, bit v mod 8). The array spans NUM_VEC rounded up to a multiple of 64 bits, and the bits beyond NUM_VEC read 0.
- R10: While msg_valid is high and msg_ready is low, msg_valid stays high and msg_addr and msg_data hold their values.
- R11: Clearing a vector's in-use bit clears its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the function control bits |
| ctl_wenable | input | 1 | New value of the enable bit |
| ctl_wmaskall | input | 1 | New value of the mask-everything bit |
| ctl_enable | output | 1 | Current enable bit |
| ctl_maskall | output | 1 | Current mask-everything bit |
| ctl_qsize | output | 11 | Table size minus one |
| tbl_we | input | 1 | Table write strobe (32-bit) |
| tbl_waddr | input | ENT_W+4 | Table write byte address |
| tbl_wdata | input | 32 | Table write data |
| tbl_raddr | input | ENT_W+4 | Table read byte address |
| tbl_rdata | output | 32 | Table read data (combinational) |
| pba_raddr | input | PBA_AW+2 | Pending array read byte address |
| pba_rdata | output | 32 | Pending array read data (combinational) |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | IDX_W | Requested vector index |
| vec_inuse | input | NUM_VEC | Per-vector in-use bits |
| msg_valid | output | 1 | Message output valid |
| msg_ready | input | 1 | Message output ready |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The bench builds the block with eight vectors, so each sweep covers every entry in full. Every entry is written and read back at every word offset. The request index runs through all sixteen values its 4-bit field can carry, which includes the eight indices beyond the table. The eight pending bits all land in the first word of a two-word array, so the upper word checks the zero padding. Because eight entries take only a few cycles to sweep, replays caused by per-vector unmasks, function mask release and enable can each be checked as a complete set of messages.

// File: rtl/mvec_pkg.sv
package mvec_pkg;
   localparam int QSIZE_W = 11;
   localparam int MAX_VEC = 2048;

   typedef enum logic [1:0] {
      W_ADDR_LO = 2'd0,
      W_ADDR_HI = 2'd1,
      W_DATA    = 2'd2,
      W_CTRL    = 2'd3
   } tbl_word_e;
endpackage

// File: rtl/mvec_entry_store.sv
module mvec_entry_store
   import mvec_pkg::*;
#(
   parameter int NUM_VEC = 8,
   parameter int ENT_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ENT_W+3:0]    wr_addr,
   input  logic [31:0]         wr_data,
   input  logic [ENT_W+3:0]    rd_addr,
   output logic [31:0]         rd_data,
   input  logic                func_mask,
   input  logic [ENT_W-1:0]    sel_idx,
   output logic [63:0]         sel_addr,
   output logic [31:0]         sel_data,
   output logic [NUM_VEC-1:0]  eff_mask,
   output logic [NUM_VEC-1:0]  unmask_edge
);
   localparam logic [ENT_W:0] VEC_LIM = (ENT_W+1)'(NUM_VEC);

   logic [NUM_VEC-1:0][63:0] ent_addr;
   logic [NUM_VEC-1:0][31:0] ent_data;
   logic [NUM_VEC-1:0]       ent_mask;
   logic [NUM_VEC-1:0]       eff_q;

   logic [ENT_W-1:0] wr_ent;
   tbl_word_e        wr_word;
   assign wr_ent  = wr_addr[ENT_W+3:4];
   assign wr_word = tbl_word_e'(wr_addr[3:2]);

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
      logic        hit;
      logic [31:0] r_lo, r_hi, r_dat;
      logic        r_msk;
      assign hit = wr_en && (wr_ent == ENT_W'(v));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            r_lo  <= '0;
            r_hi  <= '0;
            r_dat <= '0;
            r_msk <= 1'b1;
         end else if (hit) begin
            case (wr_word)
               W_ADDR_LO: r_lo  <= wr_data;
               W_ADDR_HI: r_hi  <= wr_data;
               W_DATA:    r_dat <= wr_data;
               W_CTRL:    r_msk <= wr_data[0];
               default:   ;
            endcase
         end
      end
      assign ent_addr[v] = {r_hi, r_lo};
      assign ent_data[v] = r_dat;
      assign ent_mask[v] = r_msk;
   end

   // effective mask and its falling edge against last cycle's value
   assign eff_mask    = ent_mask | {NUM_VEC{func_mask}};
   assign unmask_edge = eff_q & ~eff_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) eff_q <= '1;
      else        eff_q <= eff_mask;
   end

   logic [ENT_W-1:0] rd_ent;
   assign rd_ent = rd_addr[ENT_W+3:4];

   always_comb begin
      rd_data = '0;
      if ({1'b0, rd_ent} < VEC_LIM) begin
         case (tbl_word_e'(rd_addr[3:2]))
            W_ADDR_LO: rd_data = ent_addr[rd_ent][31:0];
            W_ADDR_HI: rd_data = ent_addr[rd_ent][63:32];
            W_DATA:    rd_data = ent_data[rd_ent];
            W_CTRL:    rd_data = {31'd0, ent_mask[rd_ent]};
            default:   rd_data = '0;
         endcase
      end
   end

   assign sel_addr = ent_addr[sel_idx];
   assign sel_data = ent_data[sel_idx];
endmodule

// File: rtl/mvec_pend_track.sv
module mvec_pend_track #(
   parameter int NUM_VEC = 8,
   parameter int IDX_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic [IDX_W-1:0]    req_idx,
   input  logic [NUM_VEC-1:0]  inuse,
   input  logic [NUM_VEC-1:0]  eff_mask,
   input  logic [NUM_VEC-1:0]  unmask_edge,
   input  logic [NUM_VEC-1:0]  take,
   output logic [NUM_VEC-1:0]  pend,
   output logic [NUM_VEC-1:0]  due
);
   logic [NUM_VEC-1:0] hit;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_hit
      assign hit[v] = req && (req_idx == IDX_W'(v)) && inuse[v];
   end

   logic [NUM_VEC-1:0] replay;
   assign replay = unmask_edge & pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         due  <= '0;
      end else begin
         pend <= ((pend & ~unmask_edge) | (hit & eff_mask)) & inuse;
         due  <= (due & ~take) | (hit & ~eff_mask) | replay;
      end
   end
endmodule

// File: rtl/mvec_msg_sweep.sv
module mvec_msg_sweep #(
   parameter int NUM_VEC = 8,
   parameter int ENT_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_VEC-1:0]  due,
   input  logic [63:0]         sel_addr,
   input  logic [31:0]         sel_data,
   output logic [ENT_W-1:0]    sel_idx,
   output logic [NUM_VEC-1:0]  take,
   output logic                msg_valid,
   input  logic                msg_ready,
   output logic [63:0]         msg_addr,
   output logic [31:0]         msg_data
);
   localparam logic [ENT_W-1:0] LAST = ENT_W'(NUM_VEC - 1);

   logic [ENT_W-1:0] ptr_q, ptr_nxt;
   logic             advance, cur_due;

   assign sel_idx = ptr_q;
   assign advance = !msg_valid || msg_ready;
   assign cur_due = due[ptr_q];

   if (NUM_VEC == 1) begin : g_single
      assign ptr_nxt = '0;
   end else begin : g_multi
      assign ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   end

   always_comb begin
      take = '0;
      if (advance && cur_due) take[ptr_q] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q     <= '0;
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else if (advance) begin
         ptr_q     <= ptr_nxt;
         msg_valid <= cur_due;
         if (cur_due) begin
            msg_addr <= sel_addr;
            msg_data <= sel_data;
         end
      end
   end
endmodule

// File: rtl/mvec_ctrl.sv
module mvec_ctrl
   import mvec_pkg::*;
#(
   parameter int NUM_VEC = 8,
   localparam int ENT_W     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
   localparam int IDX_W     = $clog2(NUM_VEC + 1),
   localparam int PBA_BITS  = ((NUM_VEC + 63) / 64) * 64,
   localparam int PBA_WORDS = PBA_BITS / 32,
   localparam int PBA_AW    = $clog2(PBA_WORDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic                 ctl_wenable,
   input  logic                 ctl_wmaskall,
   output logic                 ctl_enable,
   output logic                 ctl_maskall,
   output logic [QSIZE_W-1:0]   ctl_qsize,
   input  logic                 tbl_we,
   input  logic [ENT_W+3:0]     tbl_waddr,
   input  logic [31:0]          tbl_wdata,
   input  logic [ENT_W+3:0]     tbl_raddr,
   output logic [31:0]          tbl_rdata,
   input  logic [PBA_AW+1:0]    pba_raddr,
   output logic [31:0]          pba_rdata,
   input  logic                 irq_req,
   input  logic [IDX_W-1:0]     irq_vec,
   input  logic [NUM_VEC-1:0]   vec_inuse,
   output logic                 msg_valid,
   input  logic                 msg_ready,
   output logic [63:0]          msg_addr,
   output logic [31:0]          msg_data
);
   if (NUM_VEC < 1 || NUM_VEC > MAX_VEC) begin : g_bad_count
      $error("mvec_ctrl: NUM_VEC must lie in 1..%0d", MAX_VEC);
   end

   // function control bits
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_enable  <= 1'b0;
         ctl_maskall <= 1'b0;
      end else if (ctl_we) begin
         ctl_enable  <= ctl_wenable;
         ctl_maskall <= ctl_wmaskall;
      end
   end

   logic func_mask;
   assign func_mask = !ctl_enable || ctl_maskall;
   assign ctl_qsize = QSIZE_W'(NUM_VEC - 1);

   logic [NUM_VEC-1:0] eff_mask_w, unmask_edge_w, take_w, pend_q, due_q;
   logic [ENT_W-1:0]   sel_idx_w;
   logic [63:0]        sel_addr_w;
   logic [31:0]        sel_data_w;

   mvec_entry_store #(.NUM_VEC(NUM_VEC), .ENT_W(ENT_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_we), .wr_addr(tbl_waddr), .wr_data(tbl_wdata),
      .rd_addr(tbl_raddr), .rd_data(tbl_rdata),
      .func_mask(func_mask),
      .sel_idx(sel_idx_w), .sel_addr(sel_addr_w), .sel_data(sel_data_w),
      .eff_mask(eff_mask_w), .unmask_edge(unmask_edge_w)
   );

   mvec_pend_track #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_pend (
      .clk(clk), .rst_n(rst_n),
      .req(irq_req), .req_idx(irq_vec), .inuse(vec_inuse),
      .eff_mask(eff_mask_w), .unmask_edge(unmask_edge_w), .take(take_w),
      .pend(pend_q), .due(due_q)
   );

   mvec_msg_sweep #(.NUM_VEC(NUM_VEC), .ENT_W(ENT_W)) u_sweep (
      .clk(clk), .rst_n(rst_n),
      .due(due_q), .sel_addr(sel_addr_w), .sel_data(sel_data_w),
      .sel_idx(sel_idx_w), .take(take_w),
      .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_addr(msg_addr), .msg_data(msg_data)
   );

   // pending array: flat bit vector, zero padded to a multiple of 64
   logic [PBA_BITS-1:0] pba_flat;
   logic [PBA_AW-1:0]   pba_word;
   assign pba_flat = PBA_BITS'(pend_q);
   assign pba_word = pba_raddr[PBA_AW+1:2];

   always_comb begin
      pba_rdata = '0;
      for (int w = 0; w < PBA_WORDS; w++) begin
         if (pba_word == PBA_AW'(w)) pba_rdata = pba_flat[w*32 +: 32];
      end
   end
endmodule

// File: rtl/mvec_ctrl_chk.sv
module mvec_ctrl_chk #(
   parameter int NUM_VEC = 8,
   parameter int IDX_W   = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                irq_req,
   input logic [IDX_W-1:0]    irq_vec,
   input logic [NUM_VEC-1:0]  vec_inuse,
   input logic                msg_valid,
   input logic                msg_ready,
   input logic [63:0]         msg_addr,
   input logic [31:0]         msg_data,
   input logic [NUM_VEC-1:0]  pend,
   input logic [NUM_VEC-1:0]  eff_mask
);
   localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(NUM_VEC);

   AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R10

   AST_PEND_SET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend) & ~$past(eff_mask)) == '0)); // R4

   AST_PEND_CLR_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((~pend & $past(pend) & $past(vec_inuse) & $past(eff_mask)) == '0)); // R7

   AST_PEND_INUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(vec_inuse)) == '0)); // R11

   AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && (irq_vec >= IDX_LIM)) |=> ((pend & ~$past(pend)) == '0)); // R6
endmodule

bind mvec_ctrl mvec_ctrl_chk #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .irq_req(irq_req), .irq_vec(irq_vec), .vec_inuse(vec_inuse),
   .msg_valid(msg_valid), .msg_ready(msg_ready),
   .msg_addr(msg_addr), .msg_data(msg_data),
   .pend(pend_q), .eff_mask(eff_mask_w)
);

// File: tb/tb_mvec_ctrl.sv
`timescale 1ns/1ps
module tb_mvec_ctrl;
   localparam int NV = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0, ctl_wenable = 1'b0, ctl_wmaskall = 1'b0;
   logic        ctl_enable, ctl_maskall;
   logic [10:0] ctl_qsize;
   logic        tbl_we = 1'b0;
   logic [6:0]  tbl_waddr = '0, tbl_raddr = '0;
   logic [31:0] tbl_wdata = '0, tbl_rdata;
   logic [2:0]  pba_raddr = '0;
   logic [31:0] pba_rdata;
   logic        irq_req = 1'b0;
   logic [3:0]  irq_vec = '0;
   logic [NV-1:0] vec_inuse = '1;
   logic        msg_valid, msg_ready = 1'b1;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;

   always #4 clk = ~clk;

   mvec_ctrl #(.NUM_VEC(NV)) dut (.*);

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;
   logic [63:0] log_a [64];
   logic [31:0] log_d [64];
   int log_n = 0;

   always @(negedge clk) begin
      if (rst_n && msg_valid && msg_ready && log_n < 64) begin
         log_a[log_n] = msg_addr;
         log_d[log_n] = msg_data;
         log_n++;
      end
   end

   function automatic logic [63:0] exp_addr(int v);
      return {32'h0000_0100 + 32'(v), 32'hFEE0_0000 | (32'(v) << 4)};
   endfunction
   function automatic logic [31:0] exp_data(int v);
      return 32'h0000_5A00 + 32'(v * 3);
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic tbl_wr(input int v, input int w, input logic [31:0] d);
      tbl_we = 1'b1; tbl_waddr = 7'(v * 16 + w * 4); tbl_wdata = d;
      step(1);
      tbl_we = 1'b0;
   endtask

   task automatic tbl_rd(input int v, input int w, output logic [31:0] d);
      tbl_raddr = 7'(v * 16 + w * 4);
      #1 d = tbl_rdata;
   endtask

   task automatic pba_rd(input int w, output logic [31:0] d);
      pba_raddr = 3'(w * 4);
      #1 d = pba_rdata;
   endtask

   task automatic ctl(input logic en, input logic ma);
      ctl_we = 1'b1; ctl_wenable = en; ctl_wmaskall = ma;
      step(1);
      ctl_we = 1'b0;
   endtask

   task automatic irq(input int v);
      irq_req = 1'b1; irq_vec = 4'(v);
      step(1);
      irq_req = 1'b0;
   endtask

   // wait for the sweep to drain, then compare the set of vectors sent
   task automatic expect_msgs(input string tag, input logic [NV-1:0] exp_set);
      logic [NV-1:0] got;
      int cnt;
      step(20);
      got = '0;
      cnt = log_n;
      for (int i = 0; i < cnt; i++) begin
         for (int v = 0; v < NV; v++) begin
            if (log_a[i] == exp_addr(v) && log_d[i] == exp_data(v)) got[v] = 1'b1;
         end
      end
      chk({tag, " msg count"}, 64'(cnt), 64'($countones(exp_set)));
      chk({tag, " msg set"}, 64'(got), 64'(exp_set));
      log_n = 0;
   endtask

   task automatic expect_pba(input string tag, input logic [31:0] w0);
      logic [31:0] d;
      pba_rd(0, d); chk({tag, " pba word0"}, 64'(d), 64'(w0));
      pba_rd(1, d); chk({tag, " pba word1 padding"}, 64'(d), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      step(5);
      rst_n = 1'b1;
      step(1);

      // R1: reset state
      chk("R1 enable", 64'(ctl_enable), 64'd0);
      chk("R1 maskall", 64'(ctl_maskall), 64'd0);
      chk("R1 qsize", 64'(ctl_qsize), 64'(NV - 1));
      for (int v = 0; v < NV; v++) begin
         for (int w = 0; w < 4; w++) begin
            tbl_rd(v, w, d);
            chk($sformatf("R1 entry %0d word %0d", v, w), 64'(d), (w == 3) ? 64'd1 : 64'd0);
         end
      end
      expect_pba("R1", 32'h0);

      // R2: program every entry, read back every word
      for (int v = 0; v < NV; v++) begin
         tbl_wr(v, 0, exp_addr(v)[31:0]);
         tbl_wr(v, 1, exp_addr(v)[63:32]);
         tbl_wr(v, 2, exp_data(v));
      end
      for (int v = 0; v < NV; v++) begin
         tbl_rd(v, 0, d); chk($sformatf("R2 v%0d addr lo", v), 64'(d), 64'(exp_addr(v)[31:0]));
         tbl_rd(v, 1, d); chk($sformatf("R2 v%0d addr hi", v), 64'(d), 64'(exp_addr(v)[63:32]));
         tbl_rd(v, 2, d); chk($sformatf("R2 v%0d data", v), 64'(d), 64'(exp_data(v)));
      end
      tbl_wr(2, 3, 32'hFFFF_FFFF);
      tbl_rd(2, 3, d); chk("R2 ctrl reserved bits", 64'(d), 64'd1);
      tbl_wr(2, 3, 32'hFFFF_FFFE);
      tbl_rd(2, 3, d); chk("R2 ctrl mask only", 64'(d), 64'd0);
      tbl_wr(2, 3, 32'h1);
      expect_msgs("R7 unmask without pending", '0);

      // R3: function disabled masks an individually unmasked vector
      tbl_wr(0, 3, 32'h0);
      irq(0);
      expect_msgs("R3 disabled request", '0);
      expect_pba("R3 disabled", 32'h01);

      // R3 / R8: enabling releases the function mask and replays vector 0
      ctl(1'b1, 1'b0);
      chk("R3 enable readback", 64'(ctl_enable), 64'd1);
      expect_msgs("R8 enable replay", 8'h01);
      expect_pba("R8 after enable", 32'h00);

      // R5: unmasked request sends at once, no pending
      irq(0);
      expect_msgs("R5 direct send", 8'h01);
      expect_pba("R5", 32'h00);

      // R4 and R9: masked vectors set their own pending bits
      for (int v = 1; v < NV; v++) irq(v);
      expect_msgs("R4 masked requests", '0);
      expect_pba("R4 R9 pending layout", 32'hFE);

      // R7: per-vector unmask replays, unchanged mask does nothing
      tbl_wr(3, 3, 32'h0);
      expect_msgs("R7 unmask replay", 8'h08);
      expect_pba("R7 cleared", 32'hF6);
      tbl_wr(3, 3, 32'h0);
      expect_msgs("R7 no change", '0);

      // R6: indices beyond the table are ignored
      for (int i = NV; i < 16; i++) irq(i);
      expect_msgs("R6 out of range", '0);
      expect_pba("R6 out of range", 32'hF6);

      // R11: clearing in-use clears pending; R6: not-in-use request ignored
      vec_inuse[5] = 1'b0;
      step(2);
      expect_pba("R11 inuse cleared", 32'hD6);
      irq(5);
      expect_msgs("R6 not in use", '0);
      expect_pba("R6 not in use", 32'hD6);

      // R8: mask-everything holds back unmasked vectors, release replays them
      ctl(1'b1, 1'b1);
      irq(0); irq(3);
      expect_msgs("R3 maskall requests", '0);
      expect_pba("R3 maskall pending", 32'hDF);
      ctl(1'b1, 1'b0);
      expect_msgs("R8 maskall release", 8'h09);
      expect_pba("R8 masked stay pending", 32'hD6);

      // R10: backpressure holds the message
      msg_ready = 1'b0;
      irq(3);
      step(12);
      chk("R10 valid held", 64'(msg_valid), 64'd1);
      chk("R10 addr", msg_addr, exp_addr(3));
      step(5);
      chk("R10 addr stable", msg_addr, exp_addr(3));
      chk("R10 data stable", 64'(msg_data), 64'(exp_data(3)));
      chk("R10 nothing accepted", 64'(log_n), 64'd0);
      msg_ready = 1'b1;
      expect_msgs("R10 release", 8'h08);
      chk("R10 valid dropped", 64'(msg_valid), 64'd0);

      // R7 / R9: unmask every remaining vector, all pending replay
      for (int v = 0; v < NV; v++) tbl_wr(v, 3, 32'h0);
      expect_msgs("R7 bulk unmask", 8'hD6);
      expect_pba("R9 drained", 32'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule